// File: doc/BRIEF.md
# Gated-Count Frequency-to-Temperature Converter

This block measures the rate of a digital pulse train whose frequency encodes a sensing resistance. It turns each measurement into a scaled 13-bit control word for a downstream converter. A free-running timer opens back-to-back gating windows of 2^WIN_LOG2 clock cycles. Inside each window the block counts rising edges of the synchronised pulse input. When the window closes it latches the count and at once starts the next window.

The latched count goes through a short unsigned fixed-point pipeline. The count is shifted into a frequency value. The frequency is mapped linearly to a resistance (ten times the frequency, less a user correction term). The resistance above a baseline is multiplied by a precomputed reciprocal of the temperature coefficient times the baseline, which gives a temperature rise that is capped at the maximum admissible value. That temperature is then multiplied by a reciprocal gain and a user offset is added. Every stage carries 13-bit words.

The user constants are static inputs. Each reciprocal is supplied in Q(RECIP_FRAC) form, meaning 2^RECIP_FRAC divided by the real divisor. The block raises a one-cycle strobe for each new result.

Top module: `freq_temp_conv`

## Requirements
- R1: Results are produced once per gating window; after the first result, consecutive `valid_out` strobes are exactly 2^WIN_LOG2 clock cycles apart (16384 by default).
- R2: `valid_out` is high for exactly one clock cycle per result.
- R3: The window count equals the number of rising edges of `pulse_in` seen in the window; if it would exceed 8191 it holds at 8191 and `ovf_out` is 1 for that result, otherwise `ovf_out` is 0.
- R4: Frequency is the count shifted right by WIN_LOG2 − FREQ_UNIT_LOG2 (4 by default), i.e. count divided by the window length in units of 2^FREQ_UNIT_LOG2 cycles.
- R5: Resistance is 10 × frequency − `corr_k_in`, clamped to 0 when negative and to 8191 when larger.
- R6: Temperature rise is ((resistance − `base_r_in`) × `inv_ar_in`) >> RECIP_FRAC (12 by default), and 0 when resistance does not exceed the baseline.
- R7: The temperature rise saturates at T_MAX (400).
- R8: `ctrl_out` is ((temperature × `inv_k1_in`) >> RECIP_FRAC) + `k2_in`, saturated at 8191; so it is never below the offset.
- R9: After reset `valid_out`, `ovf_out` and `ctrl_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pulse_in | input | 1 | Pulse train to measure (asynchronous, synchronised inside) |
| corr_k_in | input | 13 | Correction term subtracted from 10 × frequency |
| base_r_in | input | 13 | Baseline resistance |
| inv_ar_in | input | 16 | Reciprocal of coefficient × baseline, Q12 |
| inv_k1_in | input | 16 | Reciprocal of the output divisor, Q12 |
| k2_in | input | 13 | Output offset |
| ctrl_out | output | 13 | Scaled control word, held between strobes |
| ovf_out | output | 1 | Counter overflow flag for the current result |
| valid_out | output | 1 | One-cycle strobe marking a new result |

## Verification
On every cycle the embedded properties check several invariants. The strobe must be one cycle wide and the count must never fall inside a window. An overflowed result must carry the full-scale count. A resistance at or below the baseline must give a zero temperature. The temperature must stay at or below its cap, and the output must never sit below the offset that was applied. The bench scenarios cover what needs whole windows of stimulus: the exact strobe spacing, the arithmetic end to end for pulse periods of 2, 4, 8 and 16 cycles, the exact 400-degree boundary, the clamp of temperatures below the baseline, counter overflow together with output saturation, and the reset state.

// File: rtl/fc_pkg.sv
// fc_pkg: shared widths and limits for the frequency-to-temperature converter.
// Assumes every datapath word is DATA_W bits and reciprocals are RCP_W bits.
package fc_pkg;
    localparam int DATA_W = 13;
    localparam int RCP_W  = 16;
    localparam int TEMP_CAP = 400;
    typedef logic [DATA_W-1:0] word_t;
    typedef logic [RCP_W-1:0]  recip_t;
    localparam word_t WORD_MAX = '1;
endpackage

// File: rtl/fc_window_counter.sv
// fc_window_counter: synchronises the pulse input, detects rising edges and
// counts them inside back-to-back windows of 2**WIN_LOG2 clock cycles.
// At the last cycle of a window the count (including that cycle's edge) is
// latched with an overflow flag, and the next window starts the cycle after.
// Assumes pulse_in may be asynchronous; a three-stage shift register is used.
module fc_window_counter #(
    parameter int CNT_W    = 13,
    parameter int WIN_LOG2 = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pulse_in,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf_o,
    output logic             done_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [2:0]          sync_q;
    logic                rise_w;
    logic [WIN_LOG2-1:0] tmr_q;
    logic                win_end;
    logic [CNT_W-1:0]    acc_q;
    logic [CNT_W-1:0]    acc_nxt;
    logic                sat_q;
    logic                sat_nxt;

    // Bring the pulse into the clock domain and keep one older sample.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[1:0], pulse_in};
    end

    assign rise_w = sync_q[1] & ~sync_q[2];

    // Free-running window timer; its wrap marks the window end.
    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_q + 1'b1;
    end

    assign win_end = &tmr_q;

    // Next count: increment on an edge, hold at full scale and flag overflow.
    always_comb begin
        acc_nxt = acc_q;
        sat_nxt = sat_q;
        if (rise_w) begin
            if (acc_q == CNT_MAX) sat_nxt = 1'b1;
            else                  acc_nxt = acc_q + 1'b1;
        end
    end

    // Running accumulator, cleared when a window closes.
    always_ff @(posedge clk) begin
        if (!rst_n || win_end) begin
            acc_q <= '0;
            sat_q <= 1'b0;
        end else begin
            acc_q <= acc_nxt;
            sat_q <= sat_nxt;
        end
    end

    // Latch the window result and mark it with a one-cycle done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o  <= '0;
            ovf_o  <= 1'b0;
            done_o <= 1'b0;
        end else begin
            done_o <= win_end;
            if (win_end) begin
                cnt_o <= acc_nxt;
                ovf_o <= sat_nxt;
            end
        end
    end

    // R3
    ovf_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && ovf_o) |-> (cnt_o == CNT_MAX));

    // R3
    acc_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(win_end) |-> (acc_q >= $past(acc_q)));
endmodule

// File: rtl/fc_res_stage.sv
// fc_res_stage: turns a latched window count into a frequency by a power-of-two
// scale, then into a resistance estimate 10*f - k, clamped into DATA_W bits.
// Assumes corr_k_i is static while results are in flight.
module fc_res_stage
    import fc_pkg::*;
#(
    parameter int CNT_W          = 13,
    parameter int WIN_LOG2       = 14,
    parameter int FREQ_UNIT_LOG2 = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             v_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             ovf_i,
    input  word_t            corr_k_i,
    output logic             v_o,
    output word_t            res_o,
    output logic             ovf_o
);
    localparam int WIDE_W = CNT_W + DATA_W + 1;
    localparam int PROD_W = DATA_W + 4;
    localparam logic [WIDE_W-1:0] WIDE_MAX = WIDE_W'(WORD_MAX);
    localparam logic [PROD_W-1:0] PROD_MAX = PROD_W'(WORD_MAX);

    logic [WIDE_W-1:0] freq_wide;
    word_t             freq_w;
    logic [PROD_W-1:0] prod10;
    logic [PROD_W-1:0] k_ext;
    logic [PROD_W-1:0] diff_w;
    word_t             res_w;

    // The window-to-unit ratio picks a right or a left shift.
    generate
        if (WIN_LOG2 >= FREQ_UNIT_LOG2) begin : g_shr
            localparam int SH_R = WIN_LOG2 - FREQ_UNIT_LOG2;
            // Divide the count by the window length in frequency units.
            always_comb freq_wide = WIDE_W'(cnt_i) >> SH_R;
        end else begin : g_shl
            localparam int SH_L = FREQ_UNIT_LOG2 - WIN_LOG2;
            // Multiply the count when the window is shorter than the unit.
            always_comb freq_wide = WIDE_W'(cnt_i) << SH_L;
        end
    endgenerate

    // Clamp the frequency into a data word.
    always_comb begin
        if (freq_wide > WIDE_MAX) freq_w = WORD_MAX;
        else                      freq_w = freq_wide[DATA_W-1:0];
    end

    // Resistance = 10*f - k, with shift-add and both-sided clamp.
    always_comb begin
        prod10 = (PROD_W'(freq_w) << 3) + (PROD_W'(freq_w) << 1);
        k_ext  = PROD_W'(corr_k_i);
        diff_w = prod10 - k_ext;
        if (prod10 <= k_ext)        res_w = '0;
        else if (diff_w > PROD_MAX) res_w = WORD_MAX;
        else                        res_w = diff_w[DATA_W-1:0];
    end

    // Register the resistance with its valid and overflow tags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_o   <= 1'b0;
            res_o <= '0;
            ovf_o <= 1'b0;
        end else begin
            v_o <= v_i;
            if (v_i) begin
                res_o <= res_w;
                ovf_o <= ovf_i;
            end
        end
    end

    // R1
    valid_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        v_i |=> v_o);

    // R5
    res_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (v_i && cnt_i == '0) |=> (res_o == '0));
endmodule

// File: rtl/fc_temp_stage.sv
// fc_temp_stage: two registered steps. First the resistance above baseline is
// multiplied by a Q(FRAC) reciprocal of alpha*R0 and capped at T_MAX; then the
// temperature is multiplied by a Q(FRAC) reciprocal of k1 and offset by k2,
// saturating at full scale. Assumes the constants are static while in flight.
module fc_temp_stage
    import fc_pkg::*;
#(
    parameter int FRAC  = 12,
    parameter int T_MAX = TEMP_CAP
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   v_i,
    input  word_t  res_i,
    input  logic   ovf_i,
    input  word_t  base_i,
    input  recip_t inv_ar_i,
    input  recip_t inv_k1_i,
    input  word_t  k2_i,
    output logic   v_o,
    output word_t  ctrl_o,
    output logic   ovf_o
);
    localparam int MUL_W = DATA_W + RCP_W;
    localparam logic [MUL_W-1:0] TCAP_W  = MUL_W'(T_MAX);
    localparam logic [MUL_W-1:0] WMAX_W  = MUL_W'(WORD_MAX);

    word_t            diff_w;
    logic [MUL_W-1:0] prod_t;
    logic [MUL_W-1:0] temp_sh;
    word_t            temp_w;
    logic             v_dt;
    word_t            dt_q;
    logic             ovf_dt;
    logic [MUL_W-1:0] prod_c;
    logic [MUL_W-1:0] sum_c;
    word_t            ctrl_w;

    // Temperature rise from resistance excess, capped at the maximum.
    always_comb begin
        diff_w  = (res_i > base_i) ? (res_i - base_i) : '0;
        prod_t  = MUL_W'(diff_w) * MUL_W'(inv_ar_i);
        temp_sh = prod_t >> FRAC;
        if (temp_sh > TCAP_W) temp_w = T_MAX[DATA_W-1:0];
        else                  temp_w = temp_sh[DATA_W-1:0];
    end

    // Register the temperature step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_dt   <= 1'b0;
            dt_q   <= '0;
            ovf_dt <= 1'b0;
        end else begin
            v_dt <= v_i;
            if (v_i) begin
                dt_q   <= temp_w;
                ovf_dt <= ovf_i;
            end
        end
    end

    // Control word: scaled temperature plus offset, saturating.
    always_comb begin
        prod_c = MUL_W'(dt_q) * MUL_W'(inv_k1_i);
        sum_c  = (prod_c >> FRAC) + MUL_W'(k2_i);
        if (sum_c > WMAX_W) ctrl_w = WORD_MAX;
        else                ctrl_w = sum_c[DATA_W-1:0];
    end

    // Register the control word and its tags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_o    <= 1'b0;
            ctrl_o <= '0;
            ovf_o  <= 1'b0;
        end else begin
            v_o <= v_dt;
            if (v_dt) begin
                ctrl_o <= ctrl_w;
                ovf_o  <= ovf_dt;
            end
        end
    end

    // R7
    temp_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        v_dt |-> (dt_q <= T_MAX[DATA_W-1:0]));

    // R6
    temp_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (v_i && (res_i <= base_i)) |=> (dt_q == '0));
endmodule

// File: rtl/freq_temp_conv.sv
// freq_temp_conv: top of the gated-count frequency-to-temperature converter.
// Chains the window counter, the resistance stage and the temperature/control
// stage; results appear with a one-cycle valid strobe once per window.
// Assumes the user constants change only between measurements.
module freq_temp_conv
    import fc_pkg::*;
#(
    parameter int WIN_LOG2       = 14,
    parameter int FREQ_UNIT_LOG2 = 10,
    parameter int RECIP_FRAC     = 12,
    parameter int T_MAX          = TEMP_CAP
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pulse_in,
    input  logic [DATA_W-1:0]   corr_k_in,
    input  logic [DATA_W-1:0]   base_r_in,
    input  logic [RCP_W-1:0]    inv_ar_in,
    input  logic [RCP_W-1:0]    inv_k1_in,
    input  logic [DATA_W-1:0]   k2_in,
    output logic [DATA_W-1:0]   ctrl_out,
    output logic                ovf_out,
    output logic                valid_out
);
    localparam int CNT_W = DATA_W;

    logic [CNT_W-1:0] cnt_w;
    logic             cnt_ovf;
    logic             cnt_done;
    logic             res_v;
    word_t            res_w;
    logic             res_ovf;

    fc_window_counter #(.CNT_W(CNT_W), .WIN_LOG2(WIN_LOG2)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .pulse_in (pulse_in),
        .cnt_o    (cnt_w),
        .ovf_o    (cnt_ovf),
        .done_o   (cnt_done)
    );

    fc_res_stage #(
        .CNT_W          (CNT_W),
        .WIN_LOG2       (WIN_LOG2),
        .FREQ_UNIT_LOG2 (FREQ_UNIT_LOG2)
    ) u_res (
        .clk      (clk),
        .rst_n    (rst_n),
        .v_i      (cnt_done),
        .cnt_i    (cnt_w),
        .ovf_i    (cnt_ovf),
        .corr_k_i (corr_k_in),
        .v_o      (res_v),
        .res_o    (res_w),
        .ovf_o    (res_ovf)
    );

    fc_temp_stage #(.FRAC(RECIP_FRAC), .T_MAX(T_MAX)) u_tmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .v_i      (res_v),
        .res_i    (res_w),
        .ovf_i    (res_ovf),
        .base_i   (base_r_in),
        .inv_ar_i (inv_ar_in),
        .inv_k1_i (inv_k1_in),
        .k2_i     (k2_in),
        .v_o      (valid_out),
        .ctrl_o   (ctrl_out),
        .ovf_o    (ovf_out)
    );

    // R2
    strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_out |=> !valid_out);

    // R8
    ctrl_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_out |-> (ctrl_out >= $past(k2_in)));
endmodule

// File: tb/freq_temp_conv_tb_top.sv
// Bench for freq_temp_conv: drives periodic pulse trains, predicts each result
// from the requirements, and tracks strobe timing on every clock.
module freq_temp_conv_tb_top;
    localparam int WIN_LOG2 = 14;
    localparam int WIN_LEN  = 1 << WIN_LOG2;
    localparam int FU_LOG2  = 10;
    localparam int FRAC     = 12;
    localparam int TCAP     = 400;
    localparam int FULL     = 8191;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pulse_in = 1'b0;
    logic [12:0] corr_k_in = 13'd20;
    logic [12:0] base_r_in = 13'd1000;
    logic [15:0] inv_ar_in = 16'd1064;
    logic [15:0] inv_k1_in = 16'd40960;
    logic [12:0] k2_in = 13'd100;
    logic [12:0] ctrl_out;
    logic        ovf_out;
    logic        valid_out;

    int checks = 0;
    int errors = 0;
    int half_per = 2;
    bit mon_on = 1'b0;

    freq_temp_conv dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pulse_in  (pulse_in),
        .corr_k_in (corr_k_in),
        .base_r_in (base_r_in),
        .inv_ar_in (inv_ar_in),
        .inv_k1_in (inv_k1_in),
        .k2_in     (k2_in),
        .ctrl_out  (ctrl_out),
        .ovf_out   (ovf_out),
        .valid_out (valid_out)
    );

    always #10 clk = ~clk;

    // Pulse source: toggles every half_per clocks.
    initial begin
        forever begin
            repeat (half_per) @(posedge clk);
            pulse_in <= ~pulse_in;
        end
    end

    task automatic check(input string req, input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    // Reference prediction for a window holding n_edges rising edges.
    task automatic predict(input int n_edges, output int exp_ctrl, output int exp_ovf);
        int cnt, freq, res, dt, c;
        cnt     = (n_edges > FULL) ? FULL : n_edges;
        exp_ovf = (n_edges > FULL) ? 1 : 0;
        freq    = cnt / (1 << (WIN_LOG2 - FU_LOG2));
        res     = 10 * freq - int'(corr_k_in);
        if (res < 0) res = 0;
        if (res > FULL) res = FULL;
        dt = (res > int'(base_r_in)) ? ((res - int'(base_r_in)) * int'(inv_ar_in)) / (1 << FRAC) : 0;
        if (dt > TCAP) dt = TCAP;
        c = (dt * int'(inv_k1_in)) / (1 << FRAC) + int'(k2_in);
        exp_ctrl = (c > FULL) ? FULL : c;
    endtask

    // Per-clock monitor: strobe width (R2) and spacing (R1).
    int cyc = 0;
    int last_v = -1;
    bit prev_v = 1'b0;
    always @(negedge clk) begin
        if (mon_on) begin
            cyc++;
            if (prev_v) check("R2 strobe one cycle", int'(valid_out), 0);
            if (valid_out && !prev_v) begin
                if (last_v >= 0) check("R1 strobe spacing", cyc - last_v, WIN_LEN);
                last_v = cyc;
            end
            prev_v = valid_out;
        end
    end

    task automatic wait_valid();
        @(negedge clk);
        while (!valid_out) @(negedge clk);
    endtask

    // One phase: set stimulus, drop the mixed window, check the next.
    task automatic run_phase(input string req, input int period);
        int ec, eo;
        half_per = period / 2;
        wait_valid();
        wait_valid();
        predict(WIN_LEN / period, ec, eo);
        check({req, " ctrl"}, int'(ctrl_out), ec);
        check({req, " ovf (R3)"}, int'(ovf_out), eo);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: reset state
        check("R9 valid after reset", int'(valid_out), 0);
        check("R9 ovf after reset", int'(ovf_out), 0);
        check("R9 ctrl after reset", int'(ctrl_out), 0);
        rst_n = 1'b1;
        mon_on = 1'b1;
        // R7 R6 R4: period 4 lands exactly on the 400-degree boundary
        run_phase("R7 boundary", 4);
        // R5 R6: mid-range temperature with truncation
        run_phase("R5 mid range", 8);
        // R6: resistance below baseline clamps temperature to 0, output = k2
        run_phase("R6 below baseline", 16);
        // R3 R7 R8: counter overflow, temperature cap and output saturation
        inv_k1_in = 16'd65535;
        k2_in     = 13'd8000;
        run_phase("R8 saturation", 2);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule